// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Splitter

This block sits between an instruction fetch buffer and the decode stage of a small byte-coded processor. It receives six bytes of instruction memory that start at the current program counter, together with that counter. It splits the leading byte into an operation nibble and a variant nibble, and works out from the operation nibble alone whether a register-pair byte and a 32-bit constant follow. It then extracts both register fields and the little-endian constant and produces the address of the next sequential instruction.

Instruction lengths are 1, 2, 5 or 6 bytes. When a register byte is present, the constant begins at byte offset 2. Otherwise it begins at offset 1. Operation codes outside the defined set, and variant nibbles outside the range their operation allows, raise an invalid flag. The stop operation raises a halt flag. The block is purely combinational: every output follows its inputs in the same cycle.

Top module: `ifs_top`

## Requirements
- R1: `icode_o` equals bits [7:4] of byte 0 and `ifun_o` equals bits [3:0] of byte 0. Byte k of the fetch window sits at bits [8k+7:8k] of `fetch_bytes_i`.
- R2: Operation codes 0x0, 0x1 and 0x9 give `len_o` = 1, with no register byte and no constant.
- R3: Operation codes 0x2, 0x6, 0xA and 0xB give `len_o` = 2, with a register byte and no constant.
- R4: Operation codes 0x3, 0x4 and 0x5 give `len_o` = 6, with both a register byte and a constant.
- R5: Operation codes 0x7 and 0x8 give `len_o` = 5, with a constant but no register byte.
- R6: When a constant is present, `valc_o` is bytes 2..5 in little-endian order if a register byte is present, and bytes 1..4 otherwise. When no constant is present, `valc_o` is 0.
- R7: With a register byte, `ra_o` is bits [7:4] of byte 1 and `rb_o` is bits [3:0] of byte 1. Without one, both are 0xF.
- R8: `next_pc_o` equals `pc_i + len_o` modulo 2^32.
- R9: `invalid_o` is 1 for operation codes 0xC–0xF (length 1, no register byte, no constant). It is also 1 when `ifun_o` exceeds 3 for code 0x6, exceeds 6 for code 0x7, or is nonzero for any other defined code. In all other cases it is 0.
- R10: `halt_o` is 1 exactly when the operation code is 0x1, whatever the variant nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Address of byte 0 of the fetch window |
| fetch_bytes_i | input | 48 | Six fetched bytes, byte 0 in the low bits |
| icode_o | output | 4 | Operation nibble |
| ifun_o | output | 4 | Variant nibble |
| ra_o | output | 4 | First register field, 0xF when absent |
| rb_o | output | 4 | Second register field, 0xF when absent |
| valc_o | output | 32 | Extracted constant, 0 when absent |
| has_reg_o | output | 1 | Register byte present |
| has_const_o | output | 1 | 32-bit constant present |
| len_o | output | 3 | Instruction length in bytes |
| next_pc_o | output | 32 | Address of next sequential instruction |
| invalid_o | output | 1 | Undefined operation or variant |
| halt_o | output | 1 | Stop operation seen |

## Verification
The halt flag and the invalid flag can be raised together. The bench provokes this with a leading byte of 0x11, a stop operation carrying a nonzero variant. For that vector it expects both flags high, a length of 1 and a next address one past the PC. A halt with variant 0 and an undefined code 0xC are also applied, so that each flag is also seen alone. The window bytes that follow these one-byte codes are loaded with non-zero data, and the bench confirms that none of it reaches the register fields or the constant.

// File: rtl/ifs_pkg.sv
package ifs_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;

    localparam logic [NIB_W-1:0] NO_REG      = 4'hF;
    localparam logic [NIB_W-1:0] ALU_FUN_MAX = 4'd3;
    localparam logic [NIB_W-1:0] JMP_FUN_MAX = 4'd6;

    typedef enum logic [NIB_W-1:0] {
        OP_NOP   = 4'h0,
        OP_HALT  = 4'h1,
        OP_RRMOV = 4'h2,
        OP_IRMOV = 4'h3,
        OP_RMMOV = 4'h4,
        OP_MRMOV = 4'h5,
        OP_ALU   = 4'h6,
        OP_JUMP  = 4'h7,
        OP_CALL  = 4'h8,
        OP_RET   = 4'h9,
        OP_PUSH  = 4'hA,
        OP_POP   = 4'hB
    } op_e;

    typedef struct packed {
        logic       has_reg;
        logic       has_const;
        logic [2:0] len;
        logic       bad;
        logic       halt;
    } shape_t;

    // Derive the instruction shape from the leading byte nibbles.
    function automatic shape_t classify(logic [NIB_W-1:0] code,
                                        logic [NIB_W-1:0] fun);
        shape_t s;
        logic   known;
        logic   fun_ok;
        s      = '0;
        known  = 1'b1;
        fun_ok = (fun == 4'd0);
        case (code)
            OP_NOP, OP_HALT, OP_RET: ;
            OP_RRMOV, OP_PUSH, OP_POP: s.has_reg = 1'b1;
            OP_ALU: begin
                s.has_reg = 1'b1;
                fun_ok    = (fun <= ALU_FUN_MAX);
            end
            OP_IRMOV, OP_RMMOV, OP_MRMOV: begin
                s.has_reg   = 1'b1;
                s.has_const = 1'b1;
            end
            OP_JUMP: begin
                s.has_const = 1'b1;
                fun_ok      = (fun <= JMP_FUN_MAX);
            end
            OP_CALL: s.has_const = 1'b1;
            default: known = 1'b0;
        endcase
        s.len  = 3'd1 + {2'b00, s.has_reg} + {s.has_const, 2'b00};
        s.bad  = !known || !fun_ok;
        s.halt = (code == OP_HALT);
        return s;
    endfunction

endpackage

// File: rtl/ifs_classify.sv
module ifs_classify
    import ifs_pkg::*;
(
    input  logic [NIB_W-1:0] code_i,
    input  logic [NIB_W-1:0] fun_i,
    output shape_t           shape_o
);

    assign shape_o = classify(code_i, fun_i);

    always_comb begin
        AST_LEN_LEGAL: assert (shape_o.len == 3'd1 || shape_o.len == 3'd2 ||
                               shape_o.len == 3'd5 || shape_o.len == 3'd6)
            else $error("illegal length %0d", shape_o.len); // R2
        AST_CONST_LONG: assert (!shape_o.has_const || shape_o.len >= 3'd5)
            else $error("constant present in short instruction"); // R4
        AST_BADCODE_SHORT: assert (code_i < 4'hC || (shape_o.bad && shape_o.len == 3'd1))
            else $error("undefined code not flagged"); // R9
    end

endmodule

// File: rtl/ifs_extract.sv
module ifs_extract
    import ifs_pkg::*;
#(
    parameter int WORD_BYTES = 4,
    parameter int BUF_BYTES  = 6
) (
    input  logic [(BUF_BYTES-1)*BYTE_W-1:0]  tail_i,
    input  logic                             has_reg_i,
    input  logic                             has_const_i,
    output logic [NIB_W-1:0]                 ra_o,
    output logic [NIB_W-1:0]                 rb_o,
    output logic [WORD_BYTES*BYTE_W-1:0]     valc_o
);

    localparam int REG_BYTE = 0;

    assign ra_o = has_reg_i ? tail_i[REG_BYTE*BYTE_W+NIB_W +: NIB_W] : NO_REG;
    assign rb_o = has_reg_i ? tail_i[REG_BYTE*BYTE_W +: NIB_W]       : NO_REG;

    for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
        logic [BYTE_W-1:0] near_b;
        logic [BYTE_W-1:0] far_b;
        assign near_b = tail_i[i*BYTE_W +: BYTE_W];
        assign far_b  = tail_i[(i+1)*BYTE_W +: BYTE_W];
        assign valc_o[i*BYTE_W +: BYTE_W] = !has_const_i ? '0 :
                                            (has_reg_i ? far_b : near_b);
    end

    always_comb begin
        AST_NOREG_FIELDS: assert (has_reg_i || (ra_o == NO_REG && rb_o == NO_REG))
            else $error("register fields not forced"); // R7
        AST_NOCONST_ZERO: assert (has_const_i || valc_o == '0)
            else $error("constant leaked"); // R6
    end

endmodule

// File: rtl/ifs_nextpc.sv
module ifs_nextpc #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [2:0]        len_i,
    output logic [ADDR_W-1:0] next_pc_o
);

    localparam int PAD_W = ADDR_W - 3;

    assign next_pc_o = pc_i + {{PAD_W{1'b0}}, len_i};

endmodule

// File: rtl/ifs_top.sv
module ifs_top
    import ifs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4,
    parameter int BUF_BYTES  = 6
) (
    input  logic [ADDR_W-1:0]            pc_i,
    input  logic [BUF_BYTES*8-1:0]       fetch_bytes_i,
    output logic [3:0]                   icode_o,
    output logic [3:0]                   ifun_o,
    output logic [3:0]                   ra_o,
    output logic [3:0]                   rb_o,
    output logic [WORD_BYTES*8-1:0]      valc_o,
    output logic                         has_reg_o,
    output logic                         has_const_o,
    output logic [2:0]                   len_o,
    output logic [ADDR_W-1:0]            next_pc_o,
    output logic                         invalid_o,
    output logic                         halt_o
);

    localparam int TAIL_W = (BUF_BYTES - 1) * BYTE_W;

    shape_t shape;

    assign icode_o = fetch_bytes_i[NIB_W +: NIB_W];
    assign ifun_o  = fetch_bytes_i[0 +: NIB_W];

    ifs_classify u_classify (
        .code_i  (icode_o),
        .fun_i   (ifun_o),
        .shape_o (shape)
    );

    ifs_extract #(
        .WORD_BYTES (WORD_BYTES),
        .BUF_BYTES  (BUF_BYTES)
    ) u_extract (
        .tail_i      (fetch_bytes_i[BYTE_W +: TAIL_W]),
        .has_reg_i   (shape.has_reg),
        .has_const_i (shape.has_const),
        .ra_o        (ra_o),
        .rb_o        (rb_o),
        .valc_o      (valc_o)
    );

    ifs_nextpc #(
        .ADDR_W (ADDR_W)
    ) u_nextpc (
        .pc_i      (pc_i),
        .len_i     (shape.len),
        .next_pc_o (next_pc_o)
    );

    assign has_reg_o   = shape.has_reg;
    assign has_const_o = shape.has_const;
    assign len_o       = shape.len;
    assign invalid_o   = shape.bad;
    assign halt_o      = shape.halt;

    always_comb begin
        AST_NEXT_PC_STEP: assert (next_pc_o - pc_i == {{(ADDR_W-3){1'b0}}, len_o})
            else $error("next pc does not match length"); // R8
    end

endmodule

// File: tb/ifs_top_tb_top.sv
module ifs_top_tb_top;

    typedef struct {
        logic [3:0]  icode, ifun, ra, rb;
        logic [31:0] valc, npc;
        logic [2:0]  len;
        logic        hr, hc, bad, halt;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc;
    logic [47:0] win;
    logic [3:0]  icode, ifun, ra, rb;
    logic [31:0] valc, npc;
    logic        hr, hc, bad, halt;
    logic [2:0]  len;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    ifs_top dut_i (
        .pc_i (pc), .fetch_bytes_i (win),
        .icode_o (icode), .ifun_o (ifun), .ra_o (ra), .rb_o (rb),
        .valc_o (valc), .has_reg_o (hr), .has_const_o (hc),
        .len_o (len), .next_pc_o (npc), .invalid_o (bad), .halt_o (halt)
    );

    // Reference model written from the requirement list.
    function automatic exp_t model(logic [31:0] p, logic [47:0] w);
        exp_t e;
        logic [7:0] b [6];
        for (int k = 0; k < 6; k++) b[k] = w[k*8 +: 8];
        e.icode = b[0][7:4];
        e.ifun  = b[0][3:0];
        case (e.icode)
            4'h2, 4'h6, 4'hA, 4'hB: begin e.len = 2; e.hr = 1; e.hc = 0; end // R3
            4'h3, 4'h4, 4'h5:       begin e.len = 6; e.hr = 1; e.hc = 1; end // R4
            4'h7, 4'h8:             begin e.len = 5; e.hr = 0; e.hc = 1; end // R5
            default:                begin e.len = 1; e.hr = 0; e.hc = 0; end // R2
        endcase
        e.ra = e.hr ? b[1][7:4] : 4'hF;                                      // R7
        e.rb = e.hr ? b[1][3:0] : 4'hF;
        if (!e.hc)     e.valc = 32'h0;                                       // R6
        else if (e.hr) e.valc = {b[5], b[4], b[3], b[2]};
        else           e.valc = {b[4], b[3], b[2], b[1]};
        e.npc = p + 32'(e.len);                                              // R8
        if (e.icode >= 4'hC)       e.bad = 1;                                // R9
        else if (e.icode == 4'h6)  e.bad = (e.ifun > 3);
        else if (e.icode == 4'h7)  e.bad = (e.ifun > 6);
        else                       e.bad = (e.ifun != 0);
        e.halt = (e.icode == 4'h1);                                          // R10
        return e;
    endfunction

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (pc=%h win=%h)", tag, act, exp, pc, win);
        end
    endtask

    task automatic drive(logic [31:0] p, logic [47:0] w);
        @(posedge clk);
        pc  = p;
        win = w;
        exp_q.push_back(model(p, w));
    endtask

    // Monitor: compare half a cycle after each drive.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                cmp("R1 icode", 32'(icode), 32'(e.icode));
                cmp("R1 ifun",  32'(ifun),  32'(e.ifun));
                cmp("R2/R3/R4/R5 len", 32'(len), 32'(e.len));
                cmp("R3/R4 has_reg", 32'(hr), 32'(e.hr));
                cmp("R4/R5 has_const", 32'(hc), 32'(e.hc));
                cmp("R6 valc", valc, e.valc);
                cmp("R7 ra", 32'(ra), 32'(e.ra));
                cmp("R7 rb", 32'(rb), 32'(e.rb));
                cmp("R8 next_pc", npc, e.npc);
                cmp("R9 invalid", 32'(bad), 32'(e.bad));
                cmp("R10 halt", 32'(halt), 32'(e.halt));
            end
        end
    end

    // Byte 0 in the low bits: w = {b5,b4,b3,b2,b1,b0}
    initial begin
        pc  = 32'h0;
        win = 48'h0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        drive(32'h0000_0000, 48'h0000_0000_0000);      // reset-state vector: nop, R2
        drive(32'h0000_0100, 48'h5566_7788_99_10);     // halt alone, R10
        drive(32'h0000_0104, 48'hAABB_CCDD_EE_11);     // halt + invalid together, R9 R10
        drive(32'h0000_0008, 48'h1111_1111_43_20);     // reg move, R3 R7
        drive(32'h0000_0010, 48'h0000_abcd_82_30);     // imm move, R4 R6
        drive(32'h0000_0020, 48'h0000_041c_64_40);     // store, R4 R6
        drive(32'h0000_0030, 48'hffff_fff4_15_50);     // load, R6
        drive(32'h0000_0040, 48'h9999_9999_06_60);     // alu add, R3
        drive(32'h0000_0044, 48'h0000_0000_21_63);     // alu xor, R3
        drive(32'h0000_0048, 48'h0000_0000_21_64);     // alu bad fun, R9
        drive(32'h0000_0050, 48'h7700_1234_56_70);     // jump, R5 R6
        drive(32'h0000_0058, 48'h5500_0000_80_76);     // jump greater, R5
        drive(32'h0000_0060, 48'h0000_0000_00_77);     // jump bad fun, R9
        drive(32'h0000_0068, 48'h2200_0000_28_80);     // call, R5
        drive(32'h0000_0070, 48'hDEAD_BEEF_12_90);     // return, R2 R7
        drive(32'h0000_0074, 48'hDEAD_BEEF_2f_a0);     // push, R3 R7
        drive(32'h0000_0078, 48'hDEAD_BEEF_3f_b0);     // pop, R3
        drive(32'h0000_007c, 48'h1234_5678_9a_c0);     // undefined code, R9
        drive(32'h0000_0080, 48'h1234_5678_9a_f5);     // undefined code, R9
        drive(32'h0000_0084, 48'h0000_0000_00_31);     // imm move bad fun, R9
        drive(32'hffff_fffe, 48'h0403_0201_21_30);     // address wrap, R8
        drive(32'hffff_fffd, 48'h0000_0000_00_80);     // address wrap on call, R8
        repeat (3) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule